// File: doc/BRIEF.md
# Character Display Host Register Port

This block is the parallel host-side port of a character display controller. A host processor talks to it over an 8-bit data bus with three control inputs: an enable strobe, a register select and a read/write line. Behind the port sit two 8-bit registers. The first is a write-only instruction register, which holds a command code or a RAM address. The second is a data register, which always holds a prefetched copy of the display or character RAM byte at the current address. A status read returns a busy flag together with the address counter. While the busy flag is set, new instructions are dropped.

A transfer takes effect when the enable strobe falls. The values of register select, read/write and the bus are taken from the last clock cycle in which enable was high. Each accepted instruction is handed on to a downstream command decoder as a one-cycle pulse. The busy flag then stays set for a fixed number of cycles. An instruction whose top bit is set also loads the address counter. Each data read advances the address counter, and the data register is then refilled from the new location through a simple combinational RAM read port.

Top module: `chp_host_port`

## Requirements
- R1: While reset is held and afterwards, until the first transfer: busy is 0, the address counter is 0, the instruction register is 0 and `cmd_valid` is 0. One cycle after reset is released, the data register holds the RAM byte at address 0.
- R2: `hst_doe` is 1 exactly when `hst_en` = 1 and `hst_rw` = 1. Whenever `hst_doe` is 0, `hst_dout` is 0.
- R3: A transfer is performed at the clock edge where enable is seen low after having been high. The type of the transfer and its data come from the last cycle in which enable was high, and bus changes made while enable is low are ignored.
- R4: An instruction write ({rs,rw} = 2'b00) that arrives while busy is 0 loads the instruction register from the bus. One cycle later, `cmd_valid` pulses for exactly one cycle, with `cmd_code` equal to the written byte. `cmd_code` then holds that value.
- R5: After an accepted instruction write, the busy flag reads 1 for exactly BUSY_CYCLES cycles and then returns to 0. A write whose transfer edge is the first cycle with busy at 0 is accepted.
- R6: An instruction write that arrives while busy is 1 is ignored. The instruction register, `cmd_code`, the address counter and the busy timing do not change, and no `cmd_valid` pulse is given.
- R7: A status read ({rs,rw} = 2'b01, enable high) drives busy on bus bit 7 and the 7-bit address counter on bits 6:0. The instruction register never appears on the bus.
- R8: An accepted instruction write with bit 7 = 1 loads the address counter from bits 6:0. `ram_addr` always equals the address counter. The cycle after the counter changes, the data register is loaded from `ram_rdata`.
- R9: A data read ({rs,rw} = 2'b11, enable high) drives the data register on the bus. At its transfer edge, the address counter increments modulo 128 and the data register is refetched.
- R10: A data write ({rs,rw} = 2'b10) changes neither the address counter, the instruction register, the data register nor the busy flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_en | input | 1 | Host enable strobe; the transfer acts when it falls |
| hst_rs | input | 1 | Register select: 0 instruction/status, 1 data |
| hst_rw | input | 1 | 1 read, 0 write |
| hst_din | input | DW | Host bus, write direction |
| hst_dout | output | DW | Host bus, read direction |
| hst_doe | output | 1 | Read data drive enable |
| ram_addr | output | AW | RAM read address (address counter) |
| ram_rdata | input | DW | RAM read data, combinational from `ram_addr` |
| cmd_valid | output | 1 | One-cycle pulse per accepted instruction |
| cmd_code | output | DW | Instruction register contents |

## Verification
Two events can fall in the same cycle. The first is the transfer edge of an instruction write. The second is the last cycle of the busy window, when the counter reaches zero. The bench provokes this by issuing a second write at a swept delay after a first accepted write, so the second transfer edge lands before, on and after the cycle where busy clears. A behavioural model in the bench decides accept or reject for each edge, and the outputs are compared with it on every clock. A second coincidence is a data read whose address step wraps from 127 to 0 while the refetch is pending. It is judged by the byte and the status word that are read next.

// File: rtl/chp_pkg.sv
package chp_pkg;

  localparam int unsigned CHP_DW = 8;
  localparam int unsigned CHP_AW = CHP_DW - 1;

  // {rs, rw} transfer kinds
  typedef enum logic [1:0] {
    XFER_INSTR_WR  = 2'b00,
    XFER_STATUS_RD = 2'b01,
    XFER_DATA_WR   = 2'b10,
    XFER_DATA_RD   = 2'b11
  } xfer_e;

  function automatic xfer_e xfer_kind(input logic rs, input logic rw);
    return xfer_e'({rs, rw});
  endfunction

endpackage

// File: rtl/chp_strobe.sv
module chp_strobe
  import chp_pkg::*;
#(
  parameter int unsigned DW = CHP_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          rs,
  input  logic          rw,
  input  logic [DW-1:0] din,
  output logic          fall,
  output xfer_e         kind,
  output logic [DW-1:0] data
);

  logic          en_q;
  logic          rs_q;
  logic          rw_q;
  logic [DW-1:0] d_q;

  // hold the bus as it was during the last high-enable cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      rs_q <= 1'b0;
      rw_q <= 1'b0;
      d_q  <= '0;
    end else begin
      en_q <= en;
      if (en) begin
        rs_q <= rs;
        rw_q <= rw;
        d_q  <= din;
      end
    end
  end

  assign fall = en_q && !en;
  assign kind = xfer_kind(rs_q, rw_q);
  assign data = d_q;

endmodule

// File: rtl/chp_busy.sv
module chp_busy #(
  parameter int unsigned BUSY_CYCLES = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int unsigned CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  function automatic logic [CNT_W-1:0] cnt_next(input logic ld, input logic [CNT_W-1:0] c);
    if (ld)
      return CNT_W'(BUSY_CYCLES);
    else if (c != '0)
      return c - CNT_W'(1);
    else
      return c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_next(start, cnt);
  end

  assign busy = (cnt != '0);

  AST_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);  // R5
  AST_BUSY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);  // R5

endmodule

// File: rtl/chp_regs.sv
module chp_regs
  import chp_pkg::*;
#(
  parameter int unsigned DW = CHP_DW,
  parameter int unsigned AW = DW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fall,
  input  xfer_e         kind,
  input  logic [DW-1:0] data,
  input  logic          busy,
  input  logic [DW-1:0] ram_rdata,
  output logic          accept,
  output logic [DW-1:0] ir,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] dr,
  output logic          cmd_valid
);

  logic instr_wr_ev;
  logic reject_ev;
  logic data_rd_ev;
  logic set_addr_ev;
  logic pf_pend;

  function automatic logic [AW-1:0] addr_step(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  assign instr_wr_ev = fall && (kind == XFER_INSTR_WR);
  assign accept      = instr_wr_ev && !busy;
  assign reject_ev   = instr_wr_ev && busy;
  assign data_rd_ev  = fall && (kind == XFER_DATA_RD);
  assign set_addr_ev = accept && data[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir        <= '0;
      cmd_valid <= 1'b0;
    end else begin
      cmd_valid <= accept;
      if (accept) ir <= data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr    <= '0;
      pf_pend <= 1'b1;
      dr      <= '0;
    end else begin
      if (set_addr_ev)     addr <= data[AW-1:0];
      else if (data_rd_ev) addr <= addr_step(addr);
      pf_pend <= set_addr_ev || data_rd_ev;
      if (pf_pend) dr <= ram_rdata;
    end
  end

  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    reject_ev |=> ($stable(ir) && $stable(addr) && !cmd_valid));  // R6
  AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);  // R4
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd_ev |=> (addr == AW'($past(addr) + AW'(1))));  // R9
  AST_PREFETCH: assert property (@(posedge clk) disable iff (!rst_n)
    pf_pend |=> (dr == $past(ram_rdata)));  // R8

endmodule

// File: rtl/chp_host_port.sv
module chp_host_port
  import chp_pkg::*;
#(
  parameter int unsigned DW          = CHP_DW,
  parameter int unsigned BUSY_CYCLES = 12,
  localparam int unsigned AW         = DW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hst_en,
  input  logic          hst_rs,
  input  logic          hst_rw,
  input  logic [DW-1:0] hst_din,
  output logic [DW-1:0] hst_dout,
  output logic          hst_doe,
  output logic [AW-1:0] ram_addr,
  input  logic [DW-1:0] ram_rdata,
  output logic          cmd_valid,
  output logic [DW-1:0] cmd_code
);

  logic          fall;
  xfer_e         kind;
  logic [DW-1:0] cap_data;
  logic          busy;
  logic          accept;
  logic [DW-1:0] ir;
  logic [AW-1:0] addr;
  logic [DW-1:0] dr;

  function automatic logic [DW-1:0] status_word(input logic b, input logic [AW-1:0] a);
    return {b, a};
  endfunction

  chp_strobe #(.DW(DW)) u_strobe (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (hst_en),
    .rs   (hst_rs),
    .rw   (hst_rw),
    .din  (hst_din),
    .fall (fall),
    .kind (kind),
    .data (cap_data)
  );

  chp_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk  (clk),
    .rst_n(rst_n),
    .start(accept),
    .busy (busy)
  );

  chp_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall     (fall),
    .kind     (kind),
    .data     (cap_data),
    .busy     (busy),
    .ram_rdata(ram_rdata),
    .accept   (accept),
    .ir       (ir),
    .addr     (addr),
    .dr       (dr),
    .cmd_valid(cmd_valid)
  );

  assign hst_doe  = hst_en && hst_rw;
  assign hst_dout = !hst_doe ? '0 : (hst_rs ? dr : status_word(busy, addr));
  assign ram_addr = addr;
  assign cmd_code = ir;

  AST_WR_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !hst_rw |-> (hst_dout == '0));  // R2
  AST_DATA_WR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && kind == XFER_DATA_WR) |=> ($stable(addr) && $stable(ir)));  // R10

endmodule

// File: tb/chp_host_port_tb.sv
module chp_host_port_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BUSY       = 9;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hst_en = 1'b0;
  logic       hst_rs = 1'b0;
  logic       hst_rw = 1'b0;
  logic [7:0] hst_din = 8'h00;
  logic [7:0] hst_dout;
  logic       hst_doe;
  logic [6:0] ram_addr;
  logic [7:0] ram_rdata;
  logic       cmd_valid;
  logic [7:0] cmd_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] ram_f(input logic [6:0] a);
    return 8'({1'b0, a} * 8'd7) ^ 8'h5A;
  endfunction

  assign ram_rdata = ram_f(ram_addr);

  chp_host_port #(.DW(8), .BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rst_n(rst_n), .hst_en(hst_en), .hst_rs(hst_rs), .hst_rw(hst_rw),
    .hst_din(hst_din), .hst_dout(hst_dout), .hst_doe(hst_doe), .ram_addr(ram_addr),
    .ram_rdata(ram_rdata), .cmd_valid(cmd_valid), .cmd_code(cmd_code)
  );

  task automatic check_eq(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit         m_en_q, m_rs, m_rw, m_pend, m_cv, m_fall, m_acc;
  logic [7:0] m_d, m_ir, m_dr;
  logic [6:0] m_addr;
  int         m_cnt;
  logic [7:0] exp_dout;
  string      dtag;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en_q = 0; m_rs = 0; m_rw = 0; m_d = 0; m_ir = 0; m_addr = 0;
      m_dr = 0; m_pend = 1; m_cnt = 0; m_cv = 0;
    end else begin
      m_fall = m_en_q && !hst_en;
      if (m_pend) m_dr = ram_f(m_addr);
      m_pend = 0;
      m_cv = 0;
      m_acc = 0;
      if (m_fall && !m_rs && !m_rw && m_cnt == 0) begin
        m_ir = m_d; m_cv = 1; m_acc = 1;
        if (m_d[7]) begin m_addr = m_d[6:0]; m_pend = 1; end
      end
      if (m_fall && m_rs && m_rw) begin
        m_addr = m_addr + 7'd1; m_pend = 1;
      end
      if (m_acc) m_cnt = BUSY;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      m_en_q = hst_en;
      if (hst_en) begin m_rs = hst_rs; m_rw = hst_rw; m_d = hst_din; end
    end
    #(CLK_PERIOD/4);
    if (rst_n === 1'b1 && !done) begin
      check_eq("R2", "doe", {7'd0, hst_doe}, {7'd0, hst_en && hst_rw});
      if (hst_en && hst_rw) begin
        exp_dout = hst_rs ? m_dr : {m_cnt != 0, m_addr};
        dtag = hst_rs ? "R9" : "R7";
      end else begin
        exp_dout = 8'h00;
        dtag = "R2";
      end
      check_eq(dtag, "dout", hst_dout, exp_dout);
      check_eq("R4", "cmd_valid", {7'd0, cmd_valid}, {7'd0, m_cv});
      check_eq("R4", "cmd_code", cmd_code, m_ir);
      check_eq("R8", "ram_addr", {1'b0, ram_addr}, {1'b0, m_addr});
    end else if (rst_n !== 1'b1) begin
      check_eq("R1", "reset cmd_valid", {7'd0, cmd_valid}, 8'h00);
      check_eq("R1", "reset ram_addr", {1'b0, ram_addr}, 8'h00);
    end
  end

  // ---------------- stimulus ----------------
  task automatic xfer(input bit rs, input bit rw, input logic [7:0] d, input int hi,
                      output logic [7:0] rd);
    @(negedge clk);
    hst_en = 1'b1; hst_rs = rs; hst_rw = rw; hst_din = d;
    repeat (hi) @(negedge clk);
    rd = hst_dout;
    hst_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < BUSY + 4; i++) begin
      xfer(1'b0, 1'b1, 8'h00, 1, s);
      if (!s[7]) return;
    end
    check_eq("R5", "busy never cleared", s, {1'b0, s[6:0]});
  endtask

  logic [7:0] rd;

  initial begin
    repeat (3) @(negedge clk);
    check_eq("R1", "cmd_code in reset", cmd_code, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    xfer(1'b0, 1'b1, 8'h00, 2, rd);
    check_eq("R1", "status after reset", rd, 8'h00);
    xfer(1'b1, 1'b1, 8'h00, 1, rd);
    check_eq("R9", "first data read", rd, ram_f(7'd0));

    xfer(1'b0, 1'b0, 8'h01, 1, rd);
    xfer(1'b0, 1'b1, 8'h00, 1, rd);
    check_eq("R5", "busy after accept", rd, 8'h81);
    xfer(1'b0, 1'b0, 8'h85, 1, rd);
    check_eq("R6", "rejected write code", cmd_code, 8'h01);
    xfer(1'b0, 1'b1, 8'h00, 1, rd);
    check_eq("R6", "address kept", {1'b0, rd[6:0]}, 8'h01);
    wait_idle();

    xfer(1'b0, 1'b0, 8'hFF, 1, rd);
    check_eq("R8", "set address code", cmd_code, 8'hFF);
    xfer(1'b1, 1'b1, 8'h00, 1, rd);
    check_eq("R8", "prefetch at 127", rd, ram_f(7'd127));
    xfer(1'b1, 1'b1, 8'h00, 1, rd);
    check_eq("R9", "wrapped read", rd, ram_f(7'd0));
    wait_idle();
    xfer(1'b0, 1'b1, 8'h00, 1, rd);
    check_eq("R9", "address after wrap", rd, 8'h01);

    xfer(1'b1, 1'b0, 8'h33, 2, rd);
    xfer(1'b0, 1'b1, 8'h00, 1, rd);
    check_eq("R10", "status after data write", rd, 8'h01);
    xfer(1'b1, 1'b1, 8'h00, 1, rd);
    check_eq("R10", "data after data write", rd, ram_f(7'd1));

    // R3: bus changes at the falling edge must not be taken
    @(negedge clk);
    hst_en = 1'b1; hst_rs = 1'b0; hst_rw = 1'b0; hst_din = 8'h8A;
    @(negedge clk);
    hst_en = 1'b0; hst_din = 8'h11; hst_rs = 1'b1;
    repeat (2) @(negedge clk);
    check_eq("R3", "captured code", cmd_code, 8'h8A);
    wait_idle();
    xfer(1'b0, 1'b1, 8'h00, 1, rd);
    check_eq("R3", "captured address", rd, 8'h0A);

    // R5/R6 boundary sweep: second write lands around busy expiry
    for (int d = BUSY - 3; d <= BUSY + 1; d++) begin
      wait_idle();
      xfer(1'b0, 1'b0, 8'h02, 1, rd);
      repeat (d) @(negedge clk);
      xfer(1'b0, 1'b0, 8'h90 + 8'(d), 1, rd);
      repeat (2) @(negedge clk);
    end
    wait_idle();

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule